// File: doc/BRIEF.md
# Timer Output Compare Unit

This block is a single 16-bit output compare channel built around its own free-running timer. A clock prescaler divides the input clock, and the timer counter advances once per prescaler period. A processor on an 8-bit bus loads a 16-bit compare value as two bytes and sets a control register with an interrupt enable and an output level. When the timer reaches the compare value, the block sets a compare flag and copies the output level into a registered output pin.

The compare value is written a byte at a time, so a match must not fire against a half-written value. A write to the upper byte therefore stops comparison, and the write to the lower byte starts it again. Clearing the flag takes two steps. Software first reads the status register while the flag is set, which arms the clear. The next lower-byte write then clears the flag. Reset leaves the compare value and the flag as they were, so software has to initialise them with this same sequence.

Top module: `tmr_oc_unit`

## Requirements
- R1: The timer count starts at 0 after reset. It increases by exactly one every PRESC_DIV input clock cycles and wraps modulo 2^16.
- R2: A write to the compare upper byte (address 2) stops comparison. No flag set and no pin update can happen until the lower byte is written.
- R3: A write to the compare lower byte (address 3) starts comparison again.
- R4: A match is tested once for each timer step. The test uses the new count and needs comparison to be running and all 16 bits to equal the compare value. A match sets the flag, which is bit 0 of the status register at address 1.
- R5: The flag clears only when a lower-byte write follows a status read that returned the flag as 1. A lower-byte write with no such read leaves the flag set. A match in the same cycle as the clear wins, and the flag stays set.
- R6: On a valid match, the pin takes the output level (control bit 1), whether or not the flag was already set.
- R7: Writing the output level does not change the pin. The pin changes only on a valid match.
- R8: Reset does not change the compare value or the flag.
- R9: The interrupt output is high exactly when the flag and the interrupt enable (control bit 0, address 0) are both 1.
- R10: Reset clears the timer, the prescaler, the arm state, the interrupt enable, the output level and the pin. Reset leaves comparison running.
- R11: A read strobe returns the selected register on bus_rdata in the next cycle. The control register reads as {6'b0, level, enable}, the status register as {7'b0, flag}, and the compare bytes read as they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address: 0 control, 1 status, 2 compare upper, 3 compare lower |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| oc_pin | output | 1 | Registered compare output |
| oc_irq | output | 1 | Compare interrupt request |
| tmr_count | output | 16 | Current timer count |

## Verification
The bench builds the block with PRESC_DIV set to 3 instead of the default 4. An odd, non-power-of-two divider exercises the general prescaler path. It also moves the points where timer steps fall out of alignment with the two-cycle bus accesses, so a byte write can land just before or just after a match test. With the shorter period, each directed scenario can place its compare target a few steps ahead of the live count and reach it in a few dozen cycles. This brings within reach the interlock window between the two byte writes, the clear racing a new match, and reset landing while the flag is set.

// File: rtl/oc_pkg.sv
package oc_pkg;
  localparam int BUS_W = 8;

  typedef enum logic [1:0] {
    OC_A_CTRL = 2'd0,
    OC_A_STAT = 2'd1,
    OC_A_CMPH = 2'd2,
    OC_A_CMPL = 2'd3
  } oc_addr_e;

  localparam int CTRL_IE_BIT  = 0;
  localparam int CTRL_LVL_BIT = 1;
  localparam int STAT_FLG_BIT = 0;
endpackage

// File: rtl/oc_timebase.sv
module oc_timebase #(
  parameter int CNT_W     = 16,
  parameter int PRESC_DIV = 4
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt,
  output logic             chk_stb
);
  localparam int PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             tick;
  logic [CNT_W-1:0] cnt_q = '0;
  logic             stb_q = 1'b0;

  generate
    if (PRESC_DIV > 1) begin : g_div
      localparam logic [PW-1:0] LAST = PW'(PRESC_DIV - 1);
      logic [PW-1:0] presc_q;
      always_ff @(posedge clk) begin
        if (rst) presc_q <= '0;
        else if (presc_q == LAST) presc_q <= '0;
        else presc_q <= presc_q + PW'(1);
      end
      assign tick = (presc_q == LAST);
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      stb_q <= 1'b0;
    end else begin
      stb_q <= tick;
      if (tick) cnt_q <= cnt_q + CNT_ONE;
    end
  end

  assign cnt     = cnt_q;
  assign chk_stb = stb_q;

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && cnt_q != $past(cnt_q)) |-> (cnt_q - $past(cnt_q) == CNT_ONE));
endmodule

// File: rtl/oc_regs.sv
module oc_regs
  import oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       addr,
  input  logic             wr,
  input  logic             rd,
  input  logic [BUS_W-1:0] wdata,
  input  logic             flag,
  output logic [BUS_W-1:0] rdata,
  output logic [CNT_W-1:0] cmp_val,
  output logic             cmp_en,
  output logic             ie,
  output logic             level,
  output logic             clr_flag
);
  localparam int HI_W = CNT_W - BUS_W;

  logic [CNT_W-1:0] cmp_q = '0;
  logic             en_q;
  logic             ie_q;
  logic             lvl_q;
  logic             arm_q;
  logic [BUS_W-1:0] rdata_q;

  logic ctrl_wr, hi_wr, lo_wr, stat_rd;
  assign ctrl_wr = wr && (addr == OC_A_CTRL);
  assign hi_wr   = wr && (addr == OC_A_CMPH);
  assign lo_wr   = wr && (addr == OC_A_CMPL);
  assign stat_rd = rd && (addr == OC_A_STAT);

  // compare bytes: untouched by reset
  always_ff @(posedge clk) begin
    if (hi_wr) cmp_q[CNT_W-1:BUS_W] <= wdata[HI_W-1:0];
    if (lo_wr) cmp_q[BUS_W-1:0]     <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b1;
      ie_q  <= 1'b0;
      lvl_q <= 1'b0;
      arm_q <= 1'b0;
    end else begin
      if (hi_wr) en_q <= 1'b0;
      else if (lo_wr) en_q <= 1'b1;
      if (ctrl_wr) begin
        ie_q  <= wdata[CTRL_IE_BIT];
        lvl_q <= wdata[CTRL_LVL_BIT];
      end
      if (lo_wr) arm_q <= 1'b0;
      else if (stat_rd && flag) arm_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (rd) begin
      rdata_q <= '0;
      case (oc_addr_e'(addr))
        OC_A_CTRL: begin
          rdata_q[CTRL_IE_BIT]  <= ie_q;
          rdata_q[CTRL_LVL_BIT] <= lvl_q;
        end
        OC_A_STAT: rdata_q[STAT_FLG_BIT] <= flag;
        OC_A_CMPH: rdata_q[HI_W-1:0] <= cmp_q[CNT_W-1:BUS_W];
        default:   rdata_q <= cmp_q[BUS_W-1:0];
      endcase
    end
  end

  assign rdata    = rdata_q;
  assign cmp_val  = cmp_q;
  assign cmp_en   = en_q;
  assign ie       = ie_q;
  assign level    = lvl_q;
  assign clr_flag = lo_wr && arm_q;

  // R2
  hi_block_chk: assert property (@(posedge clk) disable iff (rst)
    hi_wr |=> !cmp_en);
  // R3
  lo_resume_chk: assert property (@(posedge clk) disable iff (rst)
    lo_wr |=> cmp_en);
  // R5
  arm_drop_chk: assert property (@(posedge clk) disable iff (rst)
    lo_wr |=> !arm_q);
  // R10
  rst_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cmp_en && !ie && !level && !arm_q));
endmodule

// File: rtl/oc_match.sv
module oc_match #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic             chk_stb,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             cmp_en,
  input  logic             level,
  input  logic             clr_flag,
  output logic             flag,
  output logic             pin
);
  logic flag_q = 1'b0;
  logic pin_q;
  logic hit;

  assign hit = chk_stb && cmp_en && (cnt == cmp_val);

  // flag survives reset; a match wins over a clear
  always_ff @(posedge clk) begin
    if (hit) flag_q <= 1'b1;
    else if (!rst && clr_flag) flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) pin_q <= 1'b0;
    else if (hit) pin_q <= level;
  end

  assign flag = flag_q;
  assign pin  = pin_q;

  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr_flag) |=> flag_q);
  // R6
  pin_load_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> (pin_q == $past(level)));
  // R7
  pin_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(pin_q));
  // R4
  match_flag_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag_q);
endmodule

// File: rtl/tmr_oc_unit.sv
module tmr_oc_unit
  import oc_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int PRESC_DIV = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic             oc_pin,
  output logic             oc_irq,
  output logic [CNT_W-1:0] tmr_count
);
  logic [CNT_W-1:0] cnt, cmp_val;
  logic chk_stb, cmp_en, ie, level, clr_flag, flag;

  oc_timebase #(.CNT_W(CNT_W), .PRESC_DIV(PRESC_DIV)) u_tb (
    .clk(clk), .rst(rst), .cnt(cnt), .chk_stb(chk_stb));

  oc_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .flag(flag), .rdata(bus_rdata), .cmp_val(cmp_val),
    .cmp_en(cmp_en), .ie(ie), .level(level), .clr_flag(clr_flag));

  oc_match #(.CNT_W(CNT_W)) u_match (
    .clk(clk), .rst(rst), .cnt(cnt), .chk_stb(chk_stb), .cmp_val(cmp_val),
    .cmp_en(cmp_en), .level(level), .clr_flag(clr_flag), .flag(flag),
    .pin(oc_pin));

  assign oc_irq    = flag && ie;
  assign tmr_count = cnt;

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    oc_irq |-> (flag && ie));
endmodule

// File: tb/tmr_oc_unit_tb_top.sv
module tmr_oc_unit_tb_top;
  localparam int DIV = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic oc_pin, oc_irq;
  logic [15:0] tmr_count;

  always #10 clk = ~clk;

  tmr_oc_unit #(.CNT_W(16), .PRESC_DIV(DIV)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .oc_pin(oc_pin),
    .oc_irq(oc_irq), .tmr_count(tmr_count));

  int checks = 0, fails = 0;
  bit started = 0, done = 0;

  // behavioural reference
  int m_presc = 0;
  int m_cnt = 0;
  bit m_stb = 0, m_en = 1, m_arm = 0, m_ie = 0, m_lvl = 0, m_pin = 0, m_flag = 0;
  int m_cmp = 0;
  int m_rdata = 0;

  always @(posedge clk) begin
    int o_cnt, o_cmp; bit o_stb, o_en, o_arm, o_flag, o_lvl, hit;
    o_cnt = m_cnt; o_cmp = m_cmp; o_stb = m_stb; o_en = m_en;
    o_arm = m_arm; o_flag = m_flag; o_lvl = m_lvl;
    if (bus_wr && bus_addr == 2) m_cmp = (m_cmp & 255) | (bus_wdata << 8);
    if (bus_wr && bus_addr == 3) m_cmp = (m_cmp & 16'hFF00) | bus_wdata;
    if (rst) begin
      m_presc = 0; m_cnt = 0; m_stb = 0; m_en = 1; m_arm = 0;
      m_ie = 0; m_lvl = 0; m_pin = 0; m_rdata = 0;
    end else begin
      m_stb = (m_presc == DIV - 1);
      if (m_presc == DIV - 1) begin m_presc = 0; m_cnt = (m_cnt + 1) % 65536; end
      else m_presc = m_presc + 1;
      hit = o_stb && o_en && (o_cnt == o_cmp);
      if (bus_wr && bus_addr == 0) begin m_ie = bus_wdata[0]; m_lvl = bus_wdata[1]; end
      if (bus_wr && bus_addr == 2) m_en = 0;
      if (bus_wr && bus_addr == 3) begin m_en = 1; m_arm = 0; end
      else if (bus_rd && bus_addr == 1 && o_flag) m_arm = 1;
      if (bus_rd)
        case (bus_addr)
          0: m_rdata = {m_lvl_prev(o_lvl), 1'b0} | 0;
          default: m_rdata = 0;
        endcase
      if (bus_rd) begin
        case (bus_addr)
          0: m_rdata = (o_lvl ? 2 : 0) | (ie_prev ? 1 : 0);
          1: m_rdata = o_flag ? 1 : 0;
          2: m_rdata = (o_cmp >> 8) & 255;
          default: m_rdata = o_cmp & 255;
        endcase
      end
      if (hit) begin m_flag = 1; m_pin = o_lvl; end
      else if (bus_wr && bus_addr == 3 && o_arm) m_flag = 0;
    end
    ie_prev = m_ie;
  end

  bit ie_prev = 0;
  function automatic bit m_lvl_prev(bit v); return v; endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) if (started && !done) begin
    chk("R1 count", tmr_count, m_cnt);
    chk("R6 pin", oc_pin, m_pin);
    chk("R9 irq", oc_irq, m_flag && m_ie);
    chk("R11 rdata", bus_rdata, m_rdata);
  end

  task automatic wr(int a, int d);
    @(negedge clk); bus_addr = a[1:0]; bus_wdata = d[7:0]; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk); bus_addr = a[1:0]; bus_rd = 1;
    @(negedge clk); bus_rd = 0; v = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
  endtask

  task automatic set_cmp(int t);
    wr(2, (t >> 8) & 255); wr(3, t & 255);
  endtask

  initial begin
    int v, t;
    repeat (2) @(negedge clk);
    rst = 0; started = 1;
    // R10 reset state
    chk("R10 count after reset", tmr_count, 0);
    rd(0, v); chk("R10 ctrl after reset", v, 0);
    chk("R10 pin after reset", oc_pin, 0);
    // R4 R6 R9 first match
    wr(0, 3);
    t = (m_cnt + 4) % 65536; set_cmp(t);
    idle(30);
    chk("R4 flag via irq", oc_irq, 1);
    chk("R6 pin took level 1", oc_pin, 1);
    // R5 low write without arming read
    wr(3, t & 255);
    chk("R5 flag kept without read", oc_irq, 1);
    rd(1, v); chk("R11 status reads flag", v, 1);
    wr(3, t & 255);
    chk("R5 flag cleared after read+write", oc_irq, 0);
    rd(1, v); chk("R5 status after clear", v, 0);
    // R7 level write does not move pin
    wr(0, 1); idle(12);
    chk("R7 pin unchanged by level write", oc_pin, 1);
    rd(0, v); chk("R11 ctrl readback", v, 1);
    // R6 match drives 0
    t = (m_cnt + 4) % 65536; set_cmp(t); idle(30);
    chk("R6 pin took level 0", oc_pin, 0);
    // R6 with flag already set
    wr(0, 3);
    t = (m_cnt + 4) % 65536; wr(2, (t >> 8) & 255); wr(3, t & 255);
    idle(30);
    chk("R6 pin updated with flag already set", oc_pin, 1);
    // R2 interlock: clear flag, then hold upper byte pending
    wr(0, 1);
    rd(1, v);
    t = (m_cnt + 10) % 65536;
    wr(3, t & 255); wr(2, (t >> 8) & 255);
    chk("R5 cleared before interlock", oc_irq, 0);
    idle(45);
    chk("R2 no flag while pending", oc_irq, 0);
    chk("R2 pin held while pending", oc_pin, 1);
    // R3 resume
    t = (m_cnt + 5) % 65536; set_cmp(t); idle(35);
    chk("R3 match after lower byte", oc_irq, 1);
    chk("R3 pin took level 0", oc_pin, 0);
    rd(2, v); chk("R11 upper byte readback", v, (t >> 8) & 255);
    rd(3, v); chk("R11 lower byte readback", v, t & 255);
    // R8 reset keeps flag and compare
    do_reset();
    rd(1, v); chk("R8 flag kept over reset", v, 1);
    rd(2, v); chk("R8 upper kept", v, (t >> 8) & 255);
    rd(3, v); chk("R8 lower kept", v, t & 255);
    rd(0, v); chk("R10 ctrl cleared", v, 0);
    chk("R10 pin cleared", oc_pin, 0);
    // R10 comparison running after reset while upper pending before it
    rd(1, v); wr(3, 200); wr(2, 0);
    chk("R5 flag cleared", m_flag, 0);
    wr(0, 3);
    do_reset();
    wr(0, 3);
    idle(40);
    chk("R10 compare enabled after reset", oc_irq, 0);
    idle(600);
    chk("R10 match at 200 after reset", oc_irq, 1);
    chk("R10 pin after match", oc_pin, 1);
    idle(5);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule